// File: doc/BRIEF.md
# Stereo 50/15 µs De-emphasis Filter

This block removes the treble lift of pre-emphasised audio from a two-channel stream of signed samples. Each sample arrives with a one-cycle valid strobe and a channel tag. It passes through a first-order recursive shelving section. The section's coefficients are fixed for a 44.1 kHz sample rate and for time constants of 50 µs and 15 µs. The left and right channels each keep their own history, so one recursive datapath serves both channels in turn.

A run-time enable selects between the filtered result and the unchanged input. Both paths take the same number of clock cycles, so a downstream consumer sees the same timing in either mode. When the enable differs from the one that came with the previous accepted sample, the history of every channel is discarded. This stops stale state from causing a transient after a mode switch.

Control is a two-state machine. In `ST_IDLE` it waits for a strobe. On ACCEPT (a strobe seen in `ST_IDLE`) it captures the sample and moves to `ST_CALC`; with no strobe it takes the WAIT transition and stays in `ST_IDLE`. In `ST_CALC` it computes and registers the result, then takes the RETIRE transition back to `ST_IDLE` unconditionally.

Top module: `deemph_filter`

## Requirements
- R1: While reset is asserted and after its release, until the first result, `out_valid` is 0 and `out_data` is 0.
- R2: A strobe that is accepted at a rising edge k produces `out_valid` high for exactly one cycle after edge k+2, in both modes. `out_data` changes only together with `out_valid`.
- R3: A strobe presented in the cycle directly after an accepted strobe (state `ST_CALC`) is dropped. It produces no result and does not touch the channel history.
- R4: With `in_en` low, the result equals the input sample bit for bit.
- R5: With `in_en` high, the result is y = sat(floor((30114·x + (−12839)·xp + 48261·yp + 32768) / 65536)). Here xp and yp are the previous input and the previous result of the same channel.
- R6: Results outside the 18-bit two's-complement range clamp to 131071 or −131072 instead of wrapping. The clamped value is also the one stored as yp.
- R7: `in_chan` 0 selects the left history and 1 selects the right history. A sample on one channel never changes the other channel's history.
- R8: If an accepted sample's `in_en` differs from that of the previous accepted sample, xp and yp of both channels are taken as 0 for this sample. Reset counts as a previous enable of 0. A bypassed sample leaves the history unchanged.
- R9: With a constant input held on a channel, the filtered output settles to within 1 LSB of that input (unity gain at DC).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe marking a new sample |
| in_chan | input | 1 | Channel tag: 0 left, 1 right |
| in_en | input | 1 | 1 applies de-emphasis, 0 bypasses it |
| in_data | input | 18 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a result |
| out_data | output | 18 | Signed result, held between strobes |

## Verification
The assertions assume that `in_en` and `in_data` stay meaningful for the cycle in which the strobe is accepted. They also assume that strobes normally arrive at least two cycles apart, as they do at audio sample rates. The bench usually drives each strobe for one cycle with two idle cycles after it. It breaks that spacing on purpose only in the back-to-back case that R3 covers, and there it checks that no extra result appears. The channel tag and the enable change only together with a strobe, so the history that the bench's reference model tracks always matches the history of the samples that were actually accepted.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

    // Fixed-point coefficients, 16 fractional bits, valid for a 44.1 kHz rate.
    // Their sum b0 + b1 equals 65536 - fb, which gives exact unity gain at DC.
    localparam int COEF_W = 18;
    localparam int FRAC_W = 16;
    localparam logic signed [COEF_W-1:0] COEF_B0 = 18'sd30114;
    localparam logic signed [COEF_W-1:0] COEF_B1 = -18'sd12839;
    localparam logic signed [COEF_W-1:0] COEF_FB = 18'sd48261;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } dm_state_e;

endpackage

// File: rtl/deemph_ctrl.sv
module deemph_ctrl
    import deemph_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic accept,
    output logic busy,
    output logic out_valid
);

    dm_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = in_valid ? ST_CALC : ST_IDLE;  // ACCEPT / WAIT
            ST_CALC: state_nxt = ST_IDLE;                        // RETIRE
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        busy   = 1'b0;
        unique case (state)
            ST_IDLE: accept = in_valid;
            ST_CALC: busy   = 1'b1;
            default: busy   = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= busy;
        end
    end

endmodule

// File: rtl/deemph_state.sv
module deemph_state #(
    parameter int DATA_W = 18,
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_all,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic signed [DATA_W-1:0] wr_x,
    input  logic signed [DATA_W-1:0] wr_y,
    input  logic [CH_W-1:0]          rd_ch,
    output logic signed [DATA_W-1:0] rd_x,
    output logic signed [DATA_W-1:0] rd_y
);

    logic signed [DATA_W-1:0] hist_x [NUM_CH];
    logic signed [DATA_W-1:0] hist_y [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_x[g] <= '0;
                hist_y[g] <= '0;
            end else if (wr_en && (wr_ch == CH_W'(g))) begin
                hist_x[g] <= wr_x;
                hist_y[g] <= wr_y;
            end else if (clr_all) begin
                hist_x[g] <= '0;
                hist_y[g] <= '0;
            end
        end
    end

    assign rd_x = hist_x[rd_ch];
    assign rd_y = hist_y[rd_ch];

endmodule

// File: rtl/deemph_mac.sv
module deemph_mac
    import deemph_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic signed [DATA_W-1:0] x_cur,
    input  logic signed [DATA_W-1:0] x_prev,
    input  logic signed [DATA_W-1:0] y_prev,
    output logic signed [DATA_W-1:0] y_new
);

    localparam int ACC_W = DATA_W + COEF_W + 2;
    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'(2 ** (DATA_W - 1) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V = -MAX_V - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(2 ** (FRAC_W - 1));

    logic signed [ACC_W-1:0] p_b0, p_b1, p_fb, acc, quot;

    always_comb begin
        p_b0 = ACC_W'(x_cur)  * ACC_W'(COEF_B0);
        p_b1 = ACC_W'(x_prev) * ACC_W'(COEF_B1);
        p_fb = ACC_W'(y_prev) * ACC_W'(COEF_FB);
        acc  = p_b0 + p_b1 + p_fb + HALF;
        quot = acc >>> FRAC_W;
        if (quot > MAX_V) begin
            y_new = MAX_V[DATA_W-1:0];
        end else if (quot < MIN_V) begin
            y_new = MIN_V[DATA_W-1:0];
        end else begin
            y_new = quot[DATA_W-1:0];
        end
    end

endmodule

// File: rtl/deemph_filter.sv
module deemph_filter #(
    parameter int DATA_W = 18,
    parameter int NUM_CH = 2,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [CH_W-1:0]          in_chan,
    input  logic                     in_en,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    logic                     ctrl_accept, ctrl_busy;
    logic signed [DATA_W-1:0] cap_x;
    logic [CH_W-1:0]          cap_ch;
    logic                     cap_en, cap_clr, last_en;
    logic signed [DATA_W-1:0] hist_x, hist_y, use_x, use_y, y_calc;

    deemph_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .accept    (ctrl_accept),
        .busy      (ctrl_busy),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_x   <= '0;
            cap_ch  <= '0;
            cap_en  <= 1'b0;
            cap_clr <= 1'b0;
            last_en <= 1'b0;
        end else if (ctrl_accept) begin
            cap_x   <= in_data;
            cap_ch  <= in_chan;
            cap_en  <= in_en;
            cap_clr <= (in_en != last_en);
            last_en <= in_en;
        end
    end

    deemph_state #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (ctrl_busy && cap_clr),
        .wr_en   (ctrl_busy && cap_en),
        .wr_ch   (cap_ch),
        .wr_x    (cap_x),
        .wr_y    (y_calc),
        .rd_ch   (cap_ch),
        .rd_x    (hist_x),
        .rd_y    (hist_y)
    );

    assign use_x = cap_clr ? '0 : hist_x;
    assign use_y = cap_clr ? '0 : hist_y;

    deemph_mac #(
        .DATA_W (DATA_W)
    ) u_mac (
        .x_cur  (cap_x),
        .x_prev (use_x),
        .y_prev (use_y),
        .y_new  (y_calc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (ctrl_busy) begin
            out_data <= cap_en ? y_calc : cap_x;
        end
    end

endmodule

// File: rtl/deemph_filter_chk.sv
module deemph_filter_chk #(
    parameter int DATA_W = 18
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_en,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     busy,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data
);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> ##1 out_valid);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    p_no_orphan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && !busy, 2));

    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_en, 2)) |-> (out_data == $past(in_data, 2)));

endmodule

bind deemph_filter deemph_filter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_en     (in_en),
    .in_data   (in_data),
    .busy      (ctrl_busy),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/deemph_filter_bench.sv
module deemph_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [0:0]         in_chan = 1'b0;
    logic               in_en = 1'b0;
    logic signed [17:0] in_data = '0;
    logic               out_valid;
    logic signed [17:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_out = 0;
    bit finished = 1'b0;

    int    q_val[$];
    int    q_cyc[$];
    string q_tag[$];

    // reference state, built from the requirement formulas
    int m_xp[2];
    int m_yp[2];
    bit m_last_en = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    deemph_filter u_deemph_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_en     (in_en),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int ch, input bit en, input int x);
        longint acc;
        longint q;
        if (en != m_last_en) begin
            for (int c = 0; c < 2; c++) begin
                m_xp[c] = 0;
                m_yp[c] = 0;
            end
        end
        m_last_en = en;
        if (!en) return x;
        acc = 64'sd30114 * x - 64'sd12839 * m_xp[ch] + 64'sd48261 * m_yp[ch] + 64'sd32768;
        q = acc >>> 16;
        if (q > 131071) q = 131071;
        if (q < -131072) q = -131072;
        m_xp[ch] = x;
        m_yp[ch] = int'(q);
        return int'(q);
    endfunction

    task automatic send(input int ch, input bit en, input int x, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_chan  = ch[0:0];
        in_en    = en;
        in_data  = x[17:0];
        q_val.push_back(model(ch, en, x));
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 50 && q_val.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_val.size() == 0) begin
                check(1'b0, "R3 unexpected result", int'(out_data), 0);
            end else begin
                int    ev;
                int    ec;
                string et;
                ev = q_val.pop_front();
                ec = q_cyc.pop_front();
                et = q_tag.pop_front();
                check(int'(out_data) == ev, et, int'(out_data), ev);
                check(cyc == ec, "R2 latency", cyc, ec);
                last_out = int'(out_data);
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_CYCLES);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_xp[c] = 0;
            m_yp[c] = 0;
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_data == 18'sd0, "R1 data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        check(out_data == 18'sd0, "R1 data after reset", int'(out_data), 0);

        // R4: bypass passes samples unchanged
        send(0, 1'b0, 12345, "R4 bypass");
        send(1, 1'b0, -200, "R4 bypass");
        send(0, 1'b0, 131071, "R4 bypass max");
        send(1, 1'b0, -131072, "R4 bypass min");

        // R5, R7, R8: filtered impulses on interleaved channels (first one clears history)
        send(0, 1'b1, 100000, "R5 R8 filtered left");
        send(1, 1'b1, -50000, "R7 filtered right");
        for (int i = 0; i < 6; i++) begin
            send(0, 1'b1, 0, "R5 left decay");
            send(1, 1'b1, (i == 2) ? 70000 : 0, "R7 right independent");
        end
        for (int i = 0; i < 4; i++) send(0, 1'b1, -30000 + 9000 * i, "R7 left only");
        send(1, 1'b1, 4, "R7 right untouched by left");
        drain();

        // R3: a strobe directly after an accepted one is dropped
        @(negedge clk);
        in_valid = 1'b1; in_chan = 1'b0; in_en = 1'b1; in_data = 18'sd25000;
        q_val.push_back(model(0, 1'b1, 25000));
        q_cyc.push_back(cyc + 2);
        q_tag.push_back("R3 first of pair");
        @(negedge clk);
        in_data = -18'sd90000;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        send(0, 1'b1, 1000, "R3 history unaffected");
        drain();

        // R8: enable change clears both channels
        send(1, 1'b0, 777, "R8 switch to bypass");
        send(0, 1'b1, 60000, "R8 cleared left");
        send(1, 1'b1, -60000, "R8 cleared right");
        drain();

        // R9: constant input settles to itself
        for (int i = 0; i < 150; i++) begin
            send(0, 1'b1, 40000, "R9 dc left");
            send(1, 1'b1, -70000, "R9 dc right");
        end
        drain();
        check(last_out >= -70001 && last_out <= -69999, "R9 dc settle", last_out, -70000);

        // R6: full-scale inputs, clamping at the range limits
        for (int i = 0; i < 60; i++) begin
            send(0, 1'b1, 131071, "R6 full positive");
            send(1, 1'b1, -131072, "R6 full negative");
        end
        drain();
        check(last_out >= -131072 && last_out <= -131071, "R6 negative limit", last_out, -131072);
        for (int i = 0; i < 10; i++) begin
            send(0, 1'b1, (i % 2 == 0) ? -131072 : 131071, "R6 alternating");
        end
        drain();

        check(q_val.size() == 0, "R2 missing results", q_val.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule